// File: doc/BRIEF.md
# AXI4 Burst Address Generator

This block accepts one address-channel request (start address, beat-count field, transfer size and burst kind) and steps through the burst. For each beat it presents the byte address, a final-beat marker and a violation flag. A consumer advances it one beat at a time with a valid/ready step handshake. A memory model or a subordinate port would use it to work out where each data beat lands.

Each request is checked for legality when it is captured. The generator rejects these cases:
- a wrapping burst whose length is not 2, 4, 8 or 16 beats;
- a wrapping burst whose start address is not aligned to the transfer size;
- an incrementing burst that would leave its 4KB page;
- a transfer size wider than the bus;
- the reserved burst kind.

The violation flag is held on every beat of an offending burst. The beats are still produced, so the consumer can drain the burst in the normal way. The address values of a flagged burst are not specified.

Top module: `axi_burst_addr_gen`

## Requirements
- R1: A request whose beat-count field is L yields exactly L+1 beats (a field of 0 gives one beat, 255 gives 256). `beat_last` is high on the final beat only, and the cycle after that beat is taken the block is idle again.
- R2: Burst kind 2'b00 (fixed) presents the start address unchanged on every beat.
- R3: Burst kind 2'b01 (incrementing) presents the start address on beat 0. Beat i>0 gets (start aligned down to 2^size bytes) + i·2^size.
- R4: Burst kind 2'b10 (wrapping) uses a total of T = (L+1)·2^size bytes and a base equal to the start aligned down to T. Beat i is at base + ((start − base + i·2^size) mod T).
- R5: A wrapping request whose beat count is not 2, 4, 8 or 16 raises `beat_err` on all its beats. These four counts do not raise it.
- R6: A wrapping request whose start address is not a multiple of 2^size raises `beat_err`.
- R7: An incrementing request whose last byte (aligned start + total − 1) lies in a different 4KB page than its start raises `beat_err`. A burst that ends exactly on the last byte of its page does not.
- R8: A size field above the bus limit (default 5, i.e. 32 bytes per beat) raises `beat_err`.
- R9: Burst kind 2'b11 is reserved and raises `beat_err`. A legal request of any other kind keeps `beat_err` low.
- R10: After reset, and whenever no burst is in progress, `req_ready` is high and `beat_valid` is low. While a burst is in progress, `req_ready` is low and any `req_valid` has no effect on the beats.
- R11: The first beat is valid in the cycle after the request is captured. A beat that is not taken keeps its address, last marker and error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Generator idle and able to capture a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Consumer takes the presented beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |
| beat_err | output | 1 | Captured request violates a burst rule |

## Verification
The first beat is due one clock edge after the request handshake, so the bench checks `beat_valid` at the falling edge that follows the capturing edge. Every later beat replaces the previous one on the edge where valid and ready were both high. The monitor therefore compares one queued expectation at each falling edge where both are high, and checks that the beat is unchanged at falling edges that follow a stall. The return to idle comes one edge after the final beat is taken, and the driver checks it at the next falling edge after the queue empties.

// File: rtl/axbg_pkg.sv
package axbg_pkg;

    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;
    // widest total byte count: 256 beats of 128 bytes
    localparam int TOT_W  = LEN_W + 1 + (1 << SIZE_W) - 1;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_kind_e;

    typedef struct packed {
        burst_kind_e             kind;
        logic [LEN_W-1:0]        len;
        logic [SIZE_W-1:0]       size;
    } burst_shape_t;

    typedef enum logic {
        GEN_IDLE  = 1'b0,
        GEN_BURST = 1'b1
    } gen_state_e;

    function automatic logic wrap_len_ok(input logic [LEN_W-1:0] len);
        return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    endfunction

    function automatic logic [TOT_W-1:0] total_bytes(input logic [LEN_W-1:0] len,
                                                     input logic [SIZE_W-1:0] size);
        logic [TOT_W-1:0] beats;
        beats = TOT_W'(len) + TOT_W'(1);
        return beats << size;
    endfunction

endpackage

// File: rtl/axbg_legality_check.sv
module axbg_legality_check
    import axbg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_SIZE  = 5,
    parameter int PAGE_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  burst_shape_t      shape,
    output logic              violation
);
    localparam int AW1 = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [AW1-1:0]    ONE_E = {{ADDR_W{1'b0}}, 1'b1};

    logic [ADDR_W-1:0] size_mask;
    logic [ADDR_W-1:0] aligned;
    logic [AW1-1:0]    last_byte;
    logic              page_bad;
    logic              wrap_bad;
    logic              size_bad;
    logic              kind_bad;

    always_comb begin
        size_mask = (ONE_A << shape.size) - ONE_A;
        aligned   = start_addr & ~size_mask;
        last_byte = {1'b0, aligned} + AW1'(total_bytes(shape.len, shape.size)) - ONE_E;
        page_bad  = (shape.kind == BURST_INCR) &&
                    (last_byte[AW1-1:PAGE_LOG2] != {1'b0, aligned[ADDR_W-1:PAGE_LOG2]});
        wrap_bad  = (shape.kind == BURST_WRAP) &&
                    (!wrap_len_ok(shape.len) || ((start_addr & size_mask) != '0));
        kind_bad  = (shape.kind == BURST_RSVD);
    end

    generate
        if (MAX_SIZE >= (1 << SIZE_W) - 1) begin : g_size_any
            assign size_bad = 1'b0;
        end else begin : g_size_cap
            assign size_bad = (shape.size > SIZE_W'(MAX_SIZE));
        end
    endgenerate

    assign violation = page_bad | wrap_bad | size_bad | kind_bad;

endmodule

// File: rtl/axbg_geometry.sv
module axbg_geometry
    import axbg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  burst_shape_t      shape,
    output logic [ADDR_W-1:0] size_mask,
    output logic [ADDR_W-1:0] beat_bytes,
    output logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] wrap_base
);
    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] total;

    always_comb begin
        beat_bytes = ONE_A << shape.size;
        size_mask  = beat_bytes - ONE_A;
        total      = ADDR_W'(total_bytes(shape.len, shape.size));
        wrap_mask  = total - ONE_A;
        wrap_base  = start_addr & ~wrap_mask;
    end

endmodule

// File: rtl/axbg_addr_step.sv
module axbg_addr_step
    import axbg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  burst_kind_e       kind,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] size_mask,
    input  logic [ADDR_W-1:0] beat_bytes,
    input  logic [ADDR_W-1:0] wrap_mask,
    input  logic [ADDR_W-1:0] wrap_base,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] bumped;

    always_comb begin
        bumped = (cur_addr & ~size_mask) + beat_bytes;
        unique case (kind)
            BURST_INCR: next_addr = bumped;
            BURST_WRAP: next_addr = wrap_base | (bumped & wrap_mask);
            default:    next_addr = cur_addr;
        endcase
    end

endmodule

// File: rtl/axbg_beat_ctrl.sv
module axbg_beat_ctrl
    import axbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             beat_ready,
    output logic             req_ready,
    output logic             beat_valid,
    output logic             load,
    output logic             advance,
    output logic             last
);
    gen_state_e       state_q;
    logic [LEN_W-1:0] left_q;

    assign req_ready  = (state_q == GEN_IDLE);
    assign beat_valid = (state_q == GEN_BURST);
    assign last       = beat_valid && (left_q == '0);
    assign load       = req_ready && req_valid;
    assign advance    = beat_valid && beat_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                GEN_IDLE: begin
                    if (load) begin
                        state_q <= GEN_BURST;
                        left_q  <= req_len;
                    end
                end
                GEN_BURST: begin
                    if (advance) begin
                        if (left_q == '0) begin
                            state_q <= GEN_IDLE;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                        end
                    end
                end
                default: state_q <= GEN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/axi_burst_addr_gen.sv
module axi_burst_addr_gen
    import axbg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_SIZE  = 5,
    parameter int PAGE_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_len,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_burst,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last,
    output logic              beat_err
);
    burst_shape_t      shape_in;
    logic              viol_in;
    logic [ADDR_W-1:0] smask_in, bytes_in, wmask_in, wbase_in;

    burst_kind_e       kind_q;
    logic [ADDR_W-1:0] cur_q, smask_q, bytes_q, wmask_q, wbase_q;
    logic              err_q;
    logic [ADDR_W-1:0] next_addr;
    logic              load, advance;

    assign shape_in.kind = burst_kind_e'(req_burst);
    assign shape_in.len  = req_len;
    assign shape_in.size = req_size;

    axbg_legality_check #(
        .ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE), .PAGE_LOG2(PAGE_LOG2)
    ) legal_i (
        .start_addr(req_addr),
        .shape     (shape_in),
        .violation (viol_in)
    );

    axbg_geometry #(.ADDR_W(ADDR_W)) geom_i (
        .start_addr(req_addr),
        .shape     (shape_in),
        .size_mask (smask_in),
        .beat_bytes(bytes_in),
        .wrap_mask (wmask_in),
        .wrap_base (wbase_in)
    );

    axbg_beat_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_len   (req_len),
        .beat_ready(beat_ready),
        .req_ready (req_ready),
        .beat_valid(beat_valid),
        .load      (load),
        .advance   (advance),
        .last      (beat_last)
    );

    axbg_addr_step #(.ADDR_W(ADDR_W)) step_i (
        .kind      (kind_q),
        .cur_addr  (cur_q),
        .size_mask (smask_q),
        .beat_bytes(bytes_q),
        .wrap_mask (wmask_q),
        .wrap_base (wbase_q),
        .next_addr (next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= BURST_FIXED;
            cur_q   <= '0;
            smask_q <= '0;
            bytes_q <= '0;
            wmask_q <= '0;
            wbase_q <= '0;
            err_q   <= 1'b0;
        end else if (load) begin
            kind_q  <= shape_in.kind;
            cur_q   <= req_addr;
            smask_q <= smask_in;
            bytes_q <= bytes_in;
            wmask_q <= wmask_in;
            wbase_q <= wbase_in;
            err_q   <= viol_in;
        end else if (advance) begin
            cur_q   <= next_addr;
        end
    end

    assign beat_addr = cur_q;
    assign beat_err  = err_q;

endmodule

// File: rtl/axbg_checker.sv
module axbg_checker #(
    parameter int ADDR_W   = 32,
    parameter int MAX_SIZE = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [7:0]        req_len,
    input logic [2:0]        req_size,
    input logic [1:0]        req_burst,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic              beat_last,
    input logic              beat_err
);
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> !req_ready);

    assert_first_beat_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> beat_valid);

    assert_hold_beat_R11: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) &&
                                         $stable(beat_last) && $stable(beat_err)));

    assert_last_ends_R1: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && beat_last) |=> (!beat_valid && req_ready));

    assert_wrap_len_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_burst == 2'b10 &&
         !(req_len == 8'd1 || req_len == 8'd3 || req_len == 8'd7 || req_len == 8'd15))
        |=> beat_err);

    assert_size_cap_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && int'(req_size) > MAX_SIZE) |=> beat_err);

    assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_burst == 2'b11) |=> beat_err);

endmodule

bind axi_burst_addr_gen axbg_checker #(.ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_len   (req_len),
    .req_size  (req_size),
    .req_burst (req_burst),
    .beat_valid(beat_valid),
    .beat_ready(beat_ready),
    .beat_addr (beat_addr),
    .beat_last (beat_last),
    .beat_err  (beat_err)
);

// File: tb/axi_burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module axi_burst_addr_gen_tb_top;

    typedef struct {
        logic [31:0] addr;
        logic        last;
        logic        err;
        logic        chk_addr;
        string       tag;
    } beat_exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_size = '0;
    logic [1:0]  req_burst = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b1;
    logic [31:0] beat_addr;
    logic        beat_last;
    logic        beat_err;

    int          n_checks = 0;
    int          n_fails = 0;
    beat_exp_t   sb_q[$];
    logic        held_v = 1'b0;
    logic [31:0] held_a = '0;
    int unsigned cyc = 0;

    always #10 clk = ~clk;

    axi_burst_addr_gen dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_last(beat_last), .beat_err(beat_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_err(input logic [31:0] a, input logic [7:0] l,
                                     input logic [2:0] s, input logic [1:0] b);
        longint bytes, total, aligned, lastb;
        logic bad;
        bytes   = longint'(1) << s;
        total   = (longint'(l) + 1) * bytes;
        aligned = longint'(a) - (longint'(a) % bytes);
        lastb   = aligned + total - 1;
        bad = 1'b0;
        if (b == 2'b11) bad = 1'b1;
        if (s > 3'd5) bad = 1'b1;
        if (b == 2'b10 && !(l == 1 || l == 3 || l == 7 || l == 15)) bad = 1'b1;
        if (b == 2'b10 && (longint'(a) % bytes) != 0) bad = 1'b1;
        if (b == 2'b01 && (lastb / 4096) != (aligned / 4096)) bad = 1'b1;
        return bad;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [2:0] s,
                                             input logic [1:0] b, input logic [7:0] l,
                                             input int i);
        longint bytes, total, aligned, base;
        bytes   = longint'(1) << s;
        total   = (longint'(l) + 1) * bytes;
        aligned = longint'(a) - (longint'(a) % bytes);
        base    = longint'(a) - (longint'(a) % total);
        case (b)
            2'b01:   return (i == 0) ? a : 32'(aligned + longint'(i) * bytes);
            2'b10:   return 32'(base + ((longint'(a) - base + longint'(i) * bytes) % total));
            default: return a;
        endcase
    endfunction

    task automatic run_burst(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                             input logic [1:0] b, input string tag, input bit poke);
        logic e;
        e = exp_err(a, l, s, b);
        for (int i = 0; i <= int'(l); i++) begin
            beat_exp_t it;
            it.addr     = exp_addr(a, s, b, l, i);
            it.last     = (i == int'(l));
            it.err      = e;
            it.chk_addr = !e;
            it.tag      = tag;
            sb_q.push_back(it);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_len = l; req_size = s; req_burst = b; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check(beat_valid === 1'b1, "R11", "first beat valid", 32'(beat_valid), 32'd1);
        if (poke) begin
            req_addr = 32'hDEAD_0000; req_len = 8'd0; req_size = 3'd0; req_burst = 2'b01;
            req_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(req_ready === 1'b0, "R10", "ready while busy", 32'(req_ready), 32'd0);
            end
            req_valid = 1'b0;
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
        check(req_ready === 1'b1 && beat_valid === 1'b0, "R1", "idle after last",
              {30'd0, req_ready, beat_valid}, 32'h2);
    endtask

    // consumer: ready pattern changes just after rising edges
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1 beat_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
        end
    end

    // monitor: compare each taken beat against the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            held_v = 1'b0;
        end else begin
            if (held_v && beat_valid)
                check(beat_addr === held_a, "R11", "stalled beat held", beat_addr, held_a);
            if (beat_valid && beat_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected beat", beat_addr, 32'd0);
                end else begin
                    beat_exp_t it;
                    it = sb_q.pop_front();
                    check(beat_last === it.last, it.tag, "last", 32'(beat_last), 32'(it.last));
                    check(beat_err === it.err, it.tag, "err", 32'(beat_err), 32'(it.err));
                    if (it.chk_addr)
                        check(beat_addr === it.addr, it.tag, "addr", beat_addr, it.addr);
                end
            end
            held_v = beat_valid && !beat_ready;
            held_a = beat_addr;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1, "R10", "reset ready", 32'(req_ready), 32'd1);
        check(beat_valid === 1'b0, "R10", "reset valid", 32'(beat_valid), 32'd0);

        run_burst(32'h0000_1000, 8'd3,   3'd5, 2'b01, "R3", 1'b0); // 128 bytes, 4 beats
        run_burst(32'h0000_2003, 8'd4,   3'd2, 2'b01, "R3", 1'b0); // unaligned start
        run_burst(32'h0000_0000, 8'd0,   3'd2, 2'b01, "R1", 1'b0); // single beat
        run_burst(32'h0000_0000, 8'd255, 3'd0, 2'b01, "R1", 1'b0); // 256 beats
        run_burst(32'h0000_4567, 8'd7,   3'd1, 2'b00, "R2", 1'b1); // fixed, intrusion
        run_burst(32'h0000_0038, 8'd3,   3'd2, 2'b10, "R4", 1'b0); // wraps at 0x40
        run_burst(32'h0000_8140, 8'd15,  3'd5, 2'b10, "R4", 1'b0);
        run_burst(32'h0000_0106, 8'd1,   3'd1, 2'b10, "R4", 1'b0);
        run_burst(32'h0000_0220, 8'd7,   3'd3, 2'b10, "R5", 1'b0); // legal 8
        run_burst(32'h0000_0100, 8'd2,   3'd2, 2'b10, "R5", 1'b0); // 3 beats: error
        run_burst(32'h0000_0100, 8'd4,   3'd2, 2'b10, "R5", 1'b0); // 5 beats: error
        run_burst(32'h0000_0102, 8'd3,   3'd2, 2'b10, "R6", 1'b0); // misaligned
        run_burst(32'h0000_0FC0, 8'd4,   3'd4, 2'b01, "R7", 1'b0); // crosses page
        run_burst(32'h0000_0F80, 8'd3,   3'd5, 2'b01, "R7", 1'b0); // ends at 0xFFF
        run_burst(32'h0000_1FFF, 8'd1,   3'd0, 2'b01, "R7", 1'b0); // crosses by one byte
        run_burst(32'h0000_0000, 8'd1,   3'd6, 2'b01, "R8", 1'b0); // 64 bytes per beat
        run_burst(32'h0000_0300, 8'd2,   3'd5, 2'b00, "R8", 1'b0); // at the limit
        run_burst(32'h0000_0500, 8'd2,   3'd2, 2'b11, "R9", 1'b0); // reserved
        run_burst(32'h0000_0FFC, 8'd200, 3'd2, 2'b00, "R9", 1'b0); // long fixed, legal

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule